// File: doc/BRIEF.md
# Call/Return Stack Controller

This block keeps a stack in an external single-port memory and drives it through a stack-pointer register. It accepts four kinds of request: push a data word, pop a word into a result register, call a subroutine, and return from one. A call saves the current program counter on the stack and then jumps to a target address. A return restores the program counter from the top of the stack. Because return addresses and data share one stack, nested calls unwind in last-in, first-out order.

The stack grows toward lower addresses. A push or call moves the pointer down first and writes at the new address. A pop or return reads at the current pointer and moves it up afterward. The memory answers reads one cycle after the address is presented, so pops and returns take two cycles and hold `busy` high for the second one. A request that would move the pointer past either end of the stack window is refused, and a one-cycle flag reports the refusal.

Top module: `call_stack_ctrl`

## Requirements
- R1: After reset `sp` equals STACK_TOP, `pc` equals RESET_PC, and `busy`, `memWe`, `popValid`, `overflowFlag` and `underflowFlag` are all 0.
- R2: A push (`opCode` 2'b00) accepted while `sp` is above STACK_LIMIT drives `memWe`=1, `memAddr`=`sp`-1 and `memWData`=`pushData` in the accepting cycle, and `sp` becomes `sp`-1 after that edge.
- R3: A push or call accepted while `sp` equals STACK_LIMIT writes no memory, leaves `sp` and `pc` unchanged, and raises `overflowFlag` for exactly the following cycle.
- R4: A pop (`opCode` 2'b01) accepted while `sp` is below STACK_TOP presents `memAddr`=`sp`, holds `busy` high for one cycle, then shows the word read from that address on `popData` with `popValid` high for one cycle and `sp` increased by 1.
- R5: A pop or return accepted while `sp` equals STACK_TOP reads nothing into `popData` or `pc`, leaves `sp` unchanged, does not raise `busy`, and raises `underflowFlag` for exactly the following cycle.
- R6: A call (`opCode` 2'b10) accepted while `sp` is above STACK_LIMIT writes the current `pc` to address `sp`-1, decrements `sp`, and loads `pc` with `callTarget`.
- R7: A return (`opCode` 2'b11) accepted while `sp` is below STACK_TOP reads address `sp`, holds `busy` high for one cycle, then loads `pc` with that word and increments `sp`, without raising `popValid`.
- R8: Words pushed or return addresses saved are recovered in the reverse order of saving, so nested calls return to each caller in turn.
- R9: A request presented while `busy` is high is ignored: no memory write, and no change to `sp` or `pc` beyond the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request present this cycle |
| opCode | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| pushData | input | WORD_W | Word to push |
| callTarget | input | WORD_W | Subroutine address for a call |
| memAddr | output | ADDR_W | Memory address |
| memWData | output | WORD_W | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRData | input | WORD_W | Memory read data, one cycle after address |
| sp | output | ADDR_W | Stack pointer |
| pc | output | WORD_W | Program counter |
| popData | output | WORD_W | Last popped word |
| popValid | output | 1 | One-cycle strobe when popData is updated |
| busy | output | 1 | Read wait cycle in progress; requests ignored |
| overflowFlag | output | 1 | One-cycle pulse: push or call refused at the lower limit |
| underflowFlag | output | 1 | One-cycle pulse: pop or return refused on an empty stack |

## Verification
The bench keeps the defaults: an 8-bit address, 16-bit words, STACK_TOP of 104 and STACK_LIMIT of 100. That four-entry window lets a handful of pushes reach the lower limit, so the refused-push and refused-call paths are exercised alongside normal traffic. Starting at 104 also puts the empty-stack refusal on the very first request. Two levels of nested calls then unwind through the same small window.

// File: rtl/stack_ctrl_pkg.sv
package stack_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stackOp_e;

  typedef struct packed {
    logic spDec;
    logic spInc;
    logic memWrite;
    logic wrSelPc;
    logic pcLoadTarget;
    logic pcLoadMem;
    logic popLoad;
    logic ovfPulse;
    logic udfPulse;
    logic readAddr;
  } stackStrobe_t;

endpackage

// File: rtl/stack_ctrl_fsm.sv
module stack_ctrl_fsm
  import stack_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [1:0]   opCode,
  input  logic         atTop,
  input  logic         atLimit,
  output stackStrobe_t stb,
  output logic         busy
);

  typedef enum logic {S_IDLE, S_WAIT} ctrlState_e;

  ctrlState_e state, stateNext;
  logic       pendRet, pendRetNext;
  stackOp_e   op;

  assign op   = stackOp_e'(opCode);
  assign busy = (state == S_WAIT);

  always_comb begin
    stb         = '0;
    stateNext   = state;
    pendRetNext = pendRet;
    unique case (state)
      S_IDLE: begin
        if (opValid) begin
          unique case (op)
            OP_PUSH, OP_CALL: begin
              if (atLimit) begin
                stb.ovfPulse = 1'b1;
              end else begin
                stb.memWrite     = 1'b1;
                stb.spDec        = 1'b1;
                stb.wrSelPc      = (op == OP_CALL);
                stb.pcLoadTarget = (op == OP_CALL);
              end
            end
            OP_POP, OP_RET: begin
              if (atTop) begin
                stb.udfPulse = 1'b1;
              end else begin
                stb.readAddr = 1'b1;
                stateNext    = S_WAIT;
                pendRetNext  = (op == OP_RET);
              end
            end
            default: ;
          endcase
        end
      end
      S_WAIT: begin
        stb.spInc     = 1'b1;
        stb.pcLoadMem = pendRet;
        stb.popLoad   = !pendRet;
        stateNext     = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pendRet <= 1'b0;
    end else begin
      state   <= stateNext;
      pendRet <= pendRetNext;
    end
  end

  // R7: the read wait lasts exactly one cycle
  p_busy_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R9: nothing is written while a read is outstanding
  p_quiet_when_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.memWrite && !stb.ovfPulse && !stb.udfPulse);

endmodule

// File: rtl/stack_datapath.sv
module stack_datapath
  import stack_ctrl_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                WORD_W      = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP   = 8'd104,
  parameter logic [ADDR_W-1:0] STACK_LIMIT = 8'd100,
  parameter logic [WORD_W-1:0] RESET_PC    = 16'h0040
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackStrobe_t      stb,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] callTarget,
  input  logic [WORD_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              memWe,
  output logic [ADDR_W-1:0] sp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] popData,
  output logic              popValid,
  output logic              overflowFlag,
  output logic              underflowFlag,
  output logic              atTop,
  output logic              atLimit
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] spDown;

  assign spDown   = sp - ONE;
  assign atTop    = (sp == STACK_TOP);
  assign atLimit  = (sp == STACK_LIMIT);
  assign memWe    = stb.memWrite;
  assign memAddr  = stb.memWrite ? spDown : sp;
  assign memWData = stb.wrSelPc ? pc : pushData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp            <= STACK_TOP;
      pc            <= RESET_PC;
      popData       <= '0;
      popValid      <= 1'b0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (stb.spDec)        sp <= spDown;
      else if (stb.spInc)   sp <= sp + ONE;
      if (stb.pcLoadTarget) pc <= callTarget;
      else if (stb.pcLoadMem) pc <= memRData;
      if (stb.popLoad)      popData <= memRData;
      popValid      <= stb.popLoad;
      overflowFlag  <= stb.ovfPulse;
      underflowFlag <= stb.udfPulse;
    end
  end

  // R2: after a write the pointer sits on the address just written
  p_push_predec_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> sp == $past(memAddr));

  // R4: a delivered pop leaves the pointer one above the address read
  p_pop_postinc_r4: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> sp == $past(memAddr) + ONE);

  // R3: a refused push or call writes nothing and moves nothing
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> !$past(memWe) && $stable(sp) && $stable(pc));

  // R5: a refused pop or return moves nothing
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |-> $stable(sp) && $stable(pc) && !popValid);

  // R1: pointer always stays inside the stack window
  p_sp_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    sp <= STACK_TOP && sp >= STACK_LIMIT);

  // R3: flags never both pulse together
  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(overflowFlag && underflowFlag));

endmodule

// File: rtl/call_stack_ctrl.sv
module call_stack_ctrl
  import stack_ctrl_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                WORD_W      = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP   = 8'd104,
  parameter logic [ADDR_W-1:0] STACK_LIMIT = 8'd100,
  parameter logic [WORD_W-1:0] RESET_PC    = 16'h0040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] callTarget,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              memWe,
  input  logic [WORD_W-1:0] memRData,
  output logic [ADDR_W-1:0] sp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] popData,
  output logic              popValid,
  output logic              busy,
  output logic              overflowFlag,
  output logic              underflowFlag
);

  stackStrobe_t stb;
  logic         atTop;
  logic         atLimit;

  stack_ctrl_fsm u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .atTop   (atTop),
    .atLimit (atLimit),
    .stb     (stb),
    .busy    (busy)
  );

  stack_datapath #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .STACK_TOP   (STACK_TOP),
    .STACK_LIMIT (STACK_LIMIT),
    .RESET_PC    (RESET_PC)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .pushData      (pushData),
    .callTarget    (callTarget),
    .memRData      (memRData),
    .memAddr       (memAddr),
    .memWData      (memWData),
    .memWe         (memWe),
    .sp            (sp),
    .pc            (pc),
    .popData       (popData),
    .popValid      (popValid),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag),
    .atTop         (atTop),
    .atLimit       (atLimit)
  );

endmodule

// File: tb/tb_call_stack_ctrl.sv
`timescale 1ns/1ps
module tb_call_stack_ctrl;

  localparam logic [7:0]  TOP   = 8'd104;
  localparam logic [7:0]  LIM   = 8'd100;
  localparam logic [15:0] RSTPC = 16'h0040;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [15:0] pushData = '0;
  logic [15:0] callTarget = '0;
  logic [7:0]  memAddr;
  logic [15:0] memWData;
  logic        memWe;
  logic [15:0] memRData;
  logic [7:0]  sp;
  logic [15:0] pc;
  logic [15:0] popData;
  logic        popValid;
  logic        busy;
  logic        overflowFlag;
  logic        underflowFlag;

  logic [15:0] mem [256];
  int nTests = 0;
  int nFail = 0;
  logic [7:0]  expSp;
  logic [15:0] expPc;

  always #2.5 clk = ~clk;

  call_stack_ctrl dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .pushData(pushData), .callTarget(callTarget), .memAddr(memAddr),
    .memWData(memWData), .memWe(memWe), .memRData(memRData), .sp(sp),
    .pc(pc), .popData(popData), .popValid(popValid), .busy(busy),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWData;
    memRData <= mem[memAddr];
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic present(logic [1:0] op, logic [15:0] d);
    @(negedge clk);
    opValid = 1'b1; opCode = op; pushData = d; callTarget = d;
    #1;
  endtask

  task automatic release_req();
    @(negedge clk);
    opValid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 sp", sp, TOP);
    chk("R1 pc", pc, RSTPC);
    chk("R1 busy", busy, 0);
    chk("R1 memWe", memWe, 0);
    chk("R1 popValid", popValid, 0);
    chk("R1 flags", {overflowFlag, underflowFlag}, 0);
  endtask

  task automatic t_empty(logic [1:0] op);
    present(op, 16'hDEAD);
    chk("R5 no write", memWe, 0);
    release_req();
    chk("R5 underflow", underflowFlag, 1);
    chk("R5 sp held", sp, expSp);
    chk("R5 pc held", pc, expPc);
    chk("R5 no busy", busy, 0);
    chk("R5 no popValid", popValid, 0);
    @(negedge clk); #1;
    chk("R5 pulse ends", underflowFlag, 0);
  endtask

  task automatic t_push(logic [15:0] d);
    present(2'b00, d);
    chk("R2 memWe", memWe, 1);
    chk("R2 addr", memAddr, expSp - 8'd1);
    chk("R2 wdata", memWData, d);
    release_req();
    expSp = expSp - 8'd1;
    chk("R2 sp", sp, expSp);
    chk("R2 stored", mem[expSp], d);
  endtask

  task automatic t_pop(logic [15:0] expD, bit injectBusy);
    present(2'b01, 16'h0);
    chk("R4 addr", memAddr, expSp);
    chk("R4 no write", memWe, 0);
    @(negedge clk);
    if (injectBusy) begin
      opCode = 2'b10; callTarget = 16'h7777; pushData = 16'h7777;
    end else opValid = 1'b0;
    #1;
    chk("R4 busy", busy, 1);
    chk("R4 no popValid yet", popValid, 0);
    if (injectBusy) chk("R9 no write while busy", memWe, 0);
    release_req();
    expSp = expSp + 8'd1;
    chk("R4 popValid", popValid, 1);
    chk("R8 popData", popData, expD);
    chk("R4 sp", sp, expSp);
    chk("R4 busy clear", busy, 0);
    if (injectBusy) chk("R9 pc untouched", pc, expPc);
  endtask

  task automatic t_overflow();
    present(2'b00, 16'hBAD1);
    chk("R3 no write", memWe, 0);
    release_req();
    chk("R3 overflow", overflowFlag, 1);
    chk("R3 sp held", sp, LIM);
    chk("R3 mem untouched", mem[LIM - 8'd1], 16'h0);
    present(2'b10, 16'h0999);
    chk("R3 call no write", memWe, 0);
    release_req();
    chk("R3 call overflow", overflowFlag, 1);
    chk("R3 call pc held", pc, expPc);
    @(negedge clk); #1;
    chk("R3 pulse ends", overflowFlag, 0);
  endtask

  task automatic t_call(logic [15:0] tgt);
    present(2'b10, tgt);
    chk("R6 memWe", memWe, 1);
    chk("R6 addr", memAddr, expSp - 8'd1);
    chk("R6 saved pc", memWData, expPc);
    release_req();
    expSp = expSp - 8'd1;
    chk("R6 sp", sp, expSp);
    chk("R6 pc", pc, tgt);
    expPc = tgt;
  endtask

  task automatic t_ret(logic [15:0] back);
    present(2'b11, 16'h0);
    chk("R7 addr", memAddr, expSp);
    @(negedge clk); opValid = 1'b0; #1;
    chk("R7 busy", busy, 1);
    @(negedge clk); #1;
    expSp = expSp + 8'd1;
    expPc = back;
    chk("R8 pc restored", pc, back);
    chk("R7 sp", sp, expSp);
    chk("R7 no popValid", popValid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    expSp = TOP; expPc = RSTPC;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_empty(2'b01);
    t_empty(2'b11);
    t_push(16'h1111);
    t_push(16'h2222);
    t_pop(16'h2222, 1'b1);
    t_pop(16'h1111, 1'b0);
    t_push(16'hA001);
    t_push(16'hA002);
    t_push(16'hA003);
    t_push(16'hA004);
    t_overflow();
    t_pop(16'hA004, 1'b0);
    t_pop(16'hA003, 1'b0);
    t_pop(16'hA002, 1'b0);
    t_pop(16'hA001, 1'b0);
    t_empty(2'b01);
    t_call(16'h0100);
    t_call(16'h0200);
    t_ret(16'h0100);
    t_ret(RSTPC);
    t_empty(2'b11);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #100000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule